// File: doc/BRIEF.md
# Paged Pattern Memory Serializer

This block generates a stimulus bit stream for one channel. Pattern bits sit in a bank of equal-depth memory pages. At each word step a sequencer reads one bit from every active page at the current page address and assembles an output word. A parallel-to-serial stage then sends that word out one bit per clock.

Two configuration inputs select the word size. The segment resolution is given as a base-two exponent. The frequency multiplier is given as a signed base-two exponent, so fractional multipliers such as one quarter can be expressed. The word size is their product, and it also sets how many pages take part. The block clock is the serial bit clock. A new word is therefore taken every word-size cycles, which is the system rate divided by the segment resolution.

The page address runs from zero to a programmable last address and then wraps, so the pattern loops continuously. Patterns are loaded through a one-bit write port. A configuration that gives an unsupported word size raises an error flag and holds the output idle.

Top module: `paged_pattern_serializer`

## Requirements
- R1: The word size W is 2^(sr_exp + fm_exp). The serial stream is built from words of W bits, and only pages 0 to W-1 supply bits.
- R2: Within a word, bit j of the word comes from page j, and page 0 is sent first. Serial bit k of a run therefore comes from page k mod W.
- R3: Every bit of one word is read at the same page address. Word n of a run (n = k / W) uses address n, counted modulo the pattern length.
- R4: After the word at address cfg_last_addr has been sent, the next word uses address 0. The pattern repeats with a period of W*(cfg_last_addr+1) bits.
- R5: config_error is 1 in the same cycle whenever sr_exp > 4, sr_exp + fm_exp < 0, or sr_exp + fm_exp > 4. From the next clock edge on, ser_valid and ser_out stay 0 for as long as the error holds.
- R6: While run is 0, the output is idle (ser_valid = 0, ser_out = 0) from the next edge. Each new run starts at page 0, address 0.
- R7: After reset, ser_valid and ser_out are 0.
- R8: A cycle with wr_en = 1 stores wr_data at page wr_page and address wr_addr. Later runs emit the stored value.
- R9: A fractional multiplier is legal when the product still lies in 1 to 16. For example, sr_exp = 2 with fm_exp = -2 gives W = 1, and sr_exp = 1 with fm_exp = -2 is rejected.
- R10: With run = 1 and a legal configuration, serial bit k of the run appears on ser_out with ser_valid = 1 after the (k+1)-th rising edge, counted from the first edge that samples run = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sr_exp | input | 3 | Segment resolution as a base-two exponent |
| cfg_fm_exp | input | 4 | Frequency multiplier as a signed base-two exponent |
| cfg_last_addr | input | 6 | Last page address before the wrap |
| run | input | 1 | Enables generation; 0 idles and rewinds |
| wr_en | input | 1 | Pattern write strobe |
| wr_page | input | 4 | Page to write |
| wr_addr | input | 6 | Address within the page |
| wr_data | input | 1 | Bit to store |
| ser_out | output | 1 | Serial pattern bit |
| ser_valid | output | 1 | ser_out carries a pattern bit |
| config_error | output | 1 | The current configuration is illegal |

## Verification
config_error depends only on the configuration inputs, so it is checked in the cycle the inputs are applied. Serial bit k is due k+1 edges after the edge that first samples run high, and the idle state is due one edge after run falls or the configuration turns illegal. The bench changes inputs on falling edges and reads outputs on the falling edge after each rising edge. This puts each comparison exactly one edge after its cause. Expected bits are taken from a shadow copy of the written pages, indexed by page k mod W and by address (k / W) modulo the pattern length.

// File: rtl/pps_pkg.sv
// Shared widths and limits for the paged pattern serializer.
package pps_pkg;
    localparam int SR_W        = 3;  // width of the segment resolution exponent
    localparam int FM_W        = 4;  // width of the signed multiplier exponent
    localparam int MAX_SR_EXP  = 4;  // largest segment resolution exponent (SR = 16)
endpackage

// File: rtl/pps_cfg_check.sv
// Configuration checker: adds the two exponents and decides whether the
// resulting word size fits the page bank. Assumes NUM_PAGES is a power of two.
module pps_cfg_check
    import pps_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    localparam int MAX_WEXP = $clog2(NUM_PAGES),
    localparam int WEXP_W   = $clog2(MAX_WEXP + 1)
) (
    input  logic [SR_W-1:0]   sr_exp,
    input  logic [FM_W-1:0]   fm_exp,
    output logic              legal,
    output logic [WEXP_W-1:0] word_exp
);
    localparam int SUM_W = FM_W + 1;
    localparam logic [SR_W-1:0]  SR_LIMIT = SR_W'(MAX_SR_EXP);
    localparam logic signed [SUM_W-1:0] WEXP_LIMIT = SUM_W'(MAX_WEXP);

    logic signed [SUM_W-1:0] exp_sum;

    // Sum the exponents and test the result against the legal window.
    always_comb begin
        exp_sum  = $signed(SUM_W'(sr_exp)) + $signed({fm_exp[FM_W-1], fm_exp});
        legal    = (sr_exp <= SR_LIMIT) && (exp_sum >= 0) && (exp_sum <= WEXP_LIMIT);
        word_exp = legal ? exp_sum[WEXP_W-1:0] : '0;
    end
endmodule

// File: rtl/pps_page_mem.sv
// Page bank: NUM_PAGES single-bit pages with one write port and a
// combinational read of every page at a shared address. Assumes
// PAGE_DEPTH is a power of two. The storage has no reset.
module pps_page_mem #(
    parameter int NUM_PAGES  = 16,
    parameter int PAGE_DEPTH = 64,
    localparam int PAGE_W = $clog2(NUM_PAGES),
    localparam int ADDR_W = $clog2(PAGE_DEPTH)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [PAGE_W-1:0]    wr_page,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [NUM_PAGES-1:0] rd_word
);
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        logic [PAGE_DEPTH-1:0] cells;

        // Store the write bit when this page is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_page == PAGE_W'(p))) begin
                cells[wr_addr] <= wr_data;
            end
        end

        // Present this page's bit at the shared read address.
        assign rd_word[p] = cells[rd_addr];
    end
endmodule

// File: rtl/pps_sequencer.sv
// Sequencer: counts bit slots inside a word and steps the page address at
// each word end, wrapping after the last address. Inactive means rewind.
// A word size that shrinks mid-run is absorbed at the next slot.
module pps_sequencer #(
    parameter int NUM_PAGES  = 16,
    parameter int PAGE_DEPTH = 64,
    localparam int IDX_W  = $clog2(NUM_PAGES),
    localparam int ADDR_W = $clog2(PAGE_DEPTH),
    localparam int WEXP_W = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [WEXP_W-1:0] word_exp,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  bit_idx
);
    logic [IDX_W:0]   word_len;
    logic [IDX_W-1:0] idx_max;
    logic             word_end;

    // Derive the last slot index of the current word size.
    always_comb begin
        word_len = (IDX_W + 1)'(1) << word_exp;
        idx_max  = IDX_W'(word_len - 1'b1);
        word_end = (bit_idx >= idx_max);
    end

    // Advance the slot counter and the page address.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            addr    <= '0;
            bit_idx <= '0;
        end else if (word_end) begin
            bit_idx <= '0;
            addr    <= (addr >= last_addr) ? '0 : addr + 1'b1;
        end else begin
            bit_idx <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pps_serializer.sv
// Parallel-to-serial stage: registers the word bit chosen by the slot index,
// so page 0 leaves first. Drives zero when inactive.
module pps_serializer #(
    parameter int NUM_PAGES = 16,
    localparam int IDX_W = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic [NUM_PAGES-1:0] word,
    input  logic [IDX_W-1:0]     bit_idx,
    output logic                 ser_out,
    output logic                 ser_valid
);
    // Register the selected bit and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            ser_out   <= 1'b0;
            ser_valid <= 1'b0;
        end else begin
            ser_out   <= word[bit_idx];
            ser_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/paged_pattern_serializer.sv
// Top of the paged pattern serializer. Checks the configuration, steps through
// the pages and serializes each word on the bit clock. Assumes the
// configuration and pattern are changed only while run is low.
module paged_pattern_serializer
    import pps_pkg::*;
#(
    parameter int NUM_PAGES  = 16,
    parameter int PAGE_DEPTH = 64,
    localparam int PAGE_W = $clog2(NUM_PAGES),
    localparam int ADDR_W = $clog2(PAGE_DEPTH),
    localparam int WEXP_W = $clog2(PAGE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SR_W-1:0]   cfg_sr_exp,
    input  logic [FM_W-1:0]   cfg_fm_exp,
    input  logic [ADDR_W-1:0] cfg_last_addr,
    input  logic              run,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    output logic              ser_out,
    output logic              ser_valid,
    output logic              config_error
);
    logic                 cfg_legal;
    logic [WEXP_W-1:0]    word_exp;
    logic                 active;
    logic [ADDR_W-1:0]    rd_addr;
    logic [PAGE_W-1:0]    bit_idx;
    logic [NUM_PAGES-1:0] rd_word;

    // Generation runs only with run high and a legal configuration.
    assign active       = run & cfg_legal;
    assign config_error = ~cfg_legal;

    pps_cfg_check #(.NUM_PAGES(NUM_PAGES)) cfg_i (
        .sr_exp   (cfg_sr_exp),
        .fm_exp   (cfg_fm_exp),
        .legal    (cfg_legal),
        .word_exp (word_exp)
    );

    pps_sequencer #(.NUM_PAGES(NUM_PAGES), .PAGE_DEPTH(PAGE_DEPTH)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .word_exp  (word_exp),
        .last_addr (cfg_last_addr),
        .addr      (rd_addr),
        .bit_idx   (bit_idx)
    );

    pps_page_mem #(.NUM_PAGES(NUM_PAGES), .PAGE_DEPTH(PAGE_DEPTH)) mem_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_page (wr_page),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    pps_serializer #(.NUM_PAGES(NUM_PAGES)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .word      (rd_word),
        .bit_idx   (bit_idx),
        .ser_out   (ser_out),
        .ser_valid (ser_valid)
    );
endmodule

// File: rtl/pps_checker.sv
// Property checker for the paged pattern serializer, bound to the top.
module pps_checker #(
    parameter int NUM_PAGES  = 16,
    parameter int PAGE_DEPTH = 64,
    localparam int IDX_W  = $clog2(NUM_PAGES),
    localparam int ADDR_W = $clog2(PAGE_DEPTH),
    localparam int WEXP_W = $clog2(IDX_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              active,
    input logic              config_error,
    input logic              ser_out,
    input logic              ser_valid,
    input logic [WEXP_W-1:0] word_exp,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] last_addr
);
    logic [IDX_W:0] span;
    logic [IDX_W:0] idx_ext;
    assign span    = (IDX_W + 1)'(1) << word_exp;
    assign idx_ext = {1'b0, bit_idx};

    // R1: the slot index stays inside the word once the size is steady.
    a_r1_slot_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(word_exp) |-> (idx_ext < span));

    // R3: the page address holds while a word is still being sent.
    a_r3_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && (($past(idx_ext) + 1'b1) < $past(span))) |-> (addr == $past(addr)));

    // R4: the word after the last address starts again at address 0.
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && (($past(idx_ext) + 1'b1) == $past(span))
            && ($past(addr) == $past(last_addr))) |-> (addr == '0));

    // R5: an illegal configuration idles the output from the next edge.
    a_r5_idle_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |=> (!ser_valid && !ser_out));

    // R6: a low run idles the output from the next edge.
    a_r6_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ser_valid);

    // R7: no data bit is driven without valid.
    a_r7_quiet_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_out);
endmodule

bind paged_pattern_serializer pps_checker #(
    .NUM_PAGES  (NUM_PAGES),
    .PAGE_DEPTH (PAGE_DEPTH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .active       (active),
    .config_error (config_error),
    .ser_out      (ser_out),
    .ser_valid    (ser_valid),
    .word_exp     (word_exp),
    .bit_idx      (bit_idx),
    .addr         (rd_addr),
    .last_addr    (cfg_last_addr)
);

// File: tb/paged_pattern_serializer_tb_top.sv
`timescale 1ns/1ps
module paged_pattern_serializer_tb_top;
    localparam int NP = 16;
    localparam int PD = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_sr_exp = '0;
    logic [3:0] cfg_fm_exp = '0;
    logic [5:0] cfg_last_addr = '0;
    logic       run = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_page = '0;
    logic [5:0] wr_addr = '0;
    logic       wr_data = 1'b0;
    logic       ser_out, ser_valid, config_error;

    int total = 0;
    int bad = 0;
    logic [PD-1:0] shadow [NP];

    always #2 clk = ~clk;

    paged_pattern_serializer #(.NUM_PAGES(NP), .PAGE_DEPTH(PD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sr_exp(cfg_sr_exp), .cfg_fm_exp(cfg_fm_exp),
        .cfg_last_addr(cfg_last_addr), .run(run), .wr_en(wr_en), .wr_page(wr_page),
        .wr_addr(wr_addr), .wr_data(wr_data), .ser_out(ser_out),
        .ser_valid(ser_valid), .config_error(config_error)
    );

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic expect_bit(int sr, int fm, int last, int k);
        int w = 1 << (sr + fm);
        return shadow[k % w][(k / w) % (last + 1)];
    endfunction

    task automatic write_bit(int p, int a, logic d);
        @(negedge clk);
        wr_en = 1'b1; wr_page = 4'(p); wr_addr = 6'(a); wr_data = d;
        shadow[p][a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Run a legal configuration for nbits and compare every serial bit.
    task automatic play(string req, int sr, int fm, int last, int nbits);
        int errs = 0;
        @(negedge clk);
        cfg_sr_exp = 3'(sr); cfg_fm_exp = 4'(fm); cfg_last_addr = 6'(last); run = 1'b1;
        #0.5 check({req, " config_error low"}, config_error, 1'b0);
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            if (ser_valid !== 1'b1 || ser_out !== expect_bit(sr, fm, last, k)) begin
                errs++;
                if (errs == 1)
                    $display("FAIL %s bit %0d actual=%0b/%0b expected=1/%0b",
                             req, k, ser_valid, ser_out, expect_bit(sr, fm, last, k));
            end
        end
        total++;
        if (errs != 0) bad++;
        run = 1'b0;
        @(negedge clk);
        check({req, " R6 idle after stop"}, ser_valid, 1'b0);
    endtask

    task automatic reject(int sr, int fm);
        @(negedge clk);
        cfg_sr_exp = 3'(sr); cfg_fm_exp = 4'(fm); run = 1'b1;
        #0.5 check("R5 config_error raised", config_error, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R5 valid idle", ser_valid, 1'b0);
            check("R5 output idle", ser_out, 1'b0);
        end
        run = 1'b0;
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset valid", ser_valid, 1'b0);
        check("R7 reset out", ser_out, 1'b0);

        // Load every page with random bits (R8 write path).
        for (int p = 0; p < NP; p++)
            for (int a = 0; a < PD; a++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_page = 4'(p); wr_addr = 6'(a);
                wr_data = 1'($urandom);
                shadow[p][a] = wr_data;
            end
        @(negedge clk);
        wr_en = 1'b0;

        // Directed word sizes and ordering.
        play("R1 W=1", 0, 0, 5, 12);
        play("R2 W=16 page order", 4, 0, 3, 80);
        play("R3 W=4 address step", 1, 1, 7, 40);
        play("R4 W=4 wrap", 2, 0, 2, 36);
        play("R4 single address", 3, 0, 0, 24);
        play("R10 W=2 last=63", 0, 1, 63, 260);

        // Fractional multiplier, legal and rejected.
        play("R9 sr4 fm-4", 4, -4, 9, 20);
        play("R9 sr2 fm-2", 2, -2, 4, 12);
        play("R9 sr3 fm-1", 3, -1, 5, 30);
        reject(1, -2);
        reject(4, 1);
        reject(5, -2);
        reject(0, -8);

        // Stop mid-word, then restart from page 0 address 0.
        @(negedge clk);
        cfg_sr_exp = 3'd2; cfg_fm_exp = 4'd0; cfg_last_addr = 6'd5; run = 1'b1;
        repeat (7) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R6 stop mid-word", ser_valid, 1'b0);
        play("R6 restart", 2, 0, 5, 10);

        // Rewrite a bit and see it in the stream.
        write_bit(0, 0, ~shadow[0][0]);
        write_bit(1, 0, ~shadow[1][0]);
        play("R8 rewritten bits", 1, 0, 0, 4);

        // Random legal configurations.
        for (int i = 0; i < 12; i++) begin
            int sr = $urandom % 5;
            int wl = $urandom % 5;
            int last = $urandom % PD;
            int n = (1 << wl) * (last + 1) + 17;
            if (n > 1200) n = 1200;
            play("R1 random", sr, wl - sr, last, n);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule